// File: doc/BRIEF.md
# Signed-Count Arithmetic Shifter

This unit shifts a 16-bit word, or a 32-bit pair of words, by an amount taken from a second operand. It is used as an execution unit of a 16-bit processor. The amount is the low six bits of the count word, read as a two's complement number. A positive amount moves the operand toward the most significant end. A negative amount moves it toward the least significant end and copies the sign bit into the vacated positions. Along with the shifted value, the unit reports the four processor condition flags.

Three operand forms are supported. The single form shifts one word. The even-pair form shifts the concatenation high:low and returns both words. The odd-pair form builds a 32-bit value by repeating the low word in both halves and shifts that. It returns only the low 16 bits of the result, but it derives the sign and zero flags from the whole 32-bit result. The result is registered, so one request per clock can be accepted and each answer appears one cycle later.

Top module: `ash_unit`

## Requirements
- R1: The shift amount is `shift_word[5:0]` read as signed (-32..+31). Bits 15..6 are ignored, so 32 acts as -32, 60 as -4 and -33 (6'b011111) as +31.
- R2: A positive amount n shifts the operand left by n with zero fill, within 16 bits in single mode and within 32 bits in the pair modes.
- R3: A negative amount -m shifts the operand right by m and replicates its sign bit. A negative single word shifted right by 16 or more becomes 16'hFFFF.
- R4: C is the last bit shifted out. Past the operand edge, that bit is 0 on a left shift and the sign on a right shift. An amount of 0 returns the operand unchanged with C=0 and V=0.
- R5: V is 1 on a left shift if the sign bit took more than one value during the shift, counting the sign after every single-bit step. V is 0 on a right shift. For example, single 16'h0080 shifted left by 9 gives 0 with V=1 and C=1.
- R6: N is the result's top bit and Z is set when the result is all zero. Both are taken over the full working width: 16 bits in single mode, 32 bits in either pair mode.
- R7: Pair mode with `odd_pair`=0 shifts {`opnd_hi`,`opnd_lo`}. It returns the upper half on `res_hi` and the lower half on `res_lo`, and it raises `pair_wr`.
- R8: Pair mode with `odd_pair`=1 shifts {`opnd_lo`,`opnd_lo`}. Only the low 16 bits appear on `res_lo`, with `res_hi`=0 and `pair_wr`=0. The flags still come from the 32-bit result, so the returned word can be 0 with Z=0, or have bit 15 clear with N=1.
- R9: Results appear on the cycle after `in_valid`, together with `out_valid`. An idle cycle clears `out_valid`. Reset clears every output to zero.
- R10: `flags` packs N, Z, V, C into bits 3, 2, 1, 0. In single mode `res_hi` is 0 and `pair_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| dbl_mode | input | 1 | 0: single word, 1: 32-bit pair |
| odd_pair | input | 1 | In pair mode, use the low word repeated in both halves |
| opnd_hi | input | 16 | Upper operand word (even-pair form only) |
| opnd_lo | input | 16 | Lower operand word, or the single operand |
| shift_word | input | 16 | Count word; bits 5..0 are the signed amount |
| out_valid | output | 1 | Result strobe |
| res_hi | output | 16 | Upper result word (even-pair form only, else 0) |
| res_lo | output | 16 | Lower result word |
| pair_wr | output | 1 | Both result words are meaningful |
| flags | output | 4 | {N, Z, V, C} |

## Verification
The assertions assume that the control and data inputs carry known values in every cycle where `in_valid` is high. They also assume that `in_valid` is low or defined during reset, because each result property relates a request to the output one cycle later. The stimulus drives every input from one task on the falling clock edge, and it parks all inputs at zero between requests and while reset is held. Amounts are swept across all 64 count codes, with random upper count bits, for single, even-pair and odd-pair operands, so the wrapped, zero and saturating counts all occur.

// File: rtl/ash_pkg.sv
package ash_pkg;
    localparam int DATA_W  = 16;
    localparam int COUNT_W = 6;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_V = 1;
    localparam int FLAG_C = 0;

    typedef struct packed {
        logic              valid;
        logic              pair;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic [3:0]        flags;
    } ash_out_t;
endpackage

// File: rtl/ash_core.sv
module ash_core #(
    parameter int W  = 16,
    parameter int CW = 6
) (
    input  logic [W-1:0]  opnd,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  res,
    output logic          n_o,
    output logic          z_o,
    output logic          v_o,
    output logic          c_o
);
    localparam int PAD = 1 << (CW - 1);
    localparam int XW  = W + PAD;

    logic                 go_left;
    logic                 go_right;
    logic [CW-1:0]        amt;
    logic [CW:0]          win_len;
    logic [2*W-1:0]       lwide;
    logic [XW-1:0]        ext_l;
    logic [XW-1:0]        win_mask;
    logic [XW-1:0]        window;
    logic signed [XW-1:0] ext_r;
    logic signed [XW-1:0] rs_full;
    logic signed [XW-1:0] rs_prev;

    always_comb begin
        go_right = cnt[CW-1];
        go_left  = !cnt[CW-1] && (cnt != '0);
        amt      = go_right ? (~cnt + 1'b1) : cnt;

        // left path: wide shift keeps the last bit pushed past the top
        lwide    = {{W{1'b0}}, opnd} << amt;

        // sign-change window: operand followed by zero padding
        ext_l    = {opnd, {PAD{1'b0}}};
        win_len  = {1'b0, amt} + 1'b1;
        win_mask = ~({XW{1'b1}} >> win_len);
        window   = ext_l & win_mask;

        // right path: sign-extended operand
        ext_r    = $signed({{PAD{opnd[W-1]}}, opnd});
        rs_full  = ext_r >>> amt;
        rs_prev  = ext_r >>> (amt - 1'b1);

        if (go_left) begin
            res = lwide[W-1:0];
            c_o = lwide[W];
            v_o = (window != '0) && (window != win_mask);
        end else if (go_right) begin
            res = rs_full[W-1:0];
            c_o = rs_prev[0];
            v_o = 1'b0;
        end else begin
            res = opnd;
            c_o = 1'b0;
            v_o = 1'b0;
        end
        n_o = res[W-1];
        z_o = (res == '0);
    end
endmodule

// File: rtl/ash_unit.sv
module ash_unit
    import ash_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          dbl_mode,
    input  logic          odd_pair,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] opnd_lo,
    input  logic [DW-1:0] shift_word,
    output logic          out_valid,
    output logic [DW-1:0] res_hi,
    output logic [DW-1:0] res_lo,
    output logic          pair_wr,
    output logic [3:0]    flags
);
    localparam int PW = 2 * DW;

    logic [DW-1:0] s_res;
    logic          s_n, s_z, s_v, s_c;
    logic [PW-1:0] p_opnd;
    logic [PW-1:0] p_res;
    logic          p_n, p_z, p_v, p_c;

    ash_out_t st_d, st_q;

    assign p_opnd = odd_pair ? {opnd_lo, opnd_lo} : {opnd_hi, opnd_lo};

    ash_core #(.W(DW), .CW(CW)) u_single (
        .opnd (opnd_lo),
        .cnt  (shift_word[CW-1:0]),
        .res  (s_res),
        .n_o  (s_n),
        .z_o  (s_z),
        .v_o  (s_v),
        .c_o  (s_c)
    );

    ash_core #(.W(PW), .CW(CW)) u_pair (
        .opnd (p_opnd),
        .cnt  (shift_word[CW-1:0]),
        .res  (p_res),
        .n_o  (p_n),
        .z_o  (p_z),
        .v_o  (p_v),
        .c_o  (p_c)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (dbl_mode) begin
                st_d.pair           = !odd_pair;
                st_d.hi             = odd_pair ? '0 : p_res[PW-1:DW];
                st_d.lo             = p_res[DW-1:0];
                st_d.flags[FLAG_N]  = p_n;
                st_d.flags[FLAG_Z]  = p_z;
                st_d.flags[FLAG_V]  = p_v;
                st_d.flags[FLAG_C]  = p_c;
            end else begin
                st_d.lo             = s_res;
                st_d.flags[FLAG_N]  = s_n;
                st_d.flags[FLAG_Z]  = s_z;
                st_d.flags[FLAG_V]  = s_v;
                st_d.flags[FLAG_C]  = s_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign pair_wr   = st_q.pair;
    assign res_hi    = st_q.hi;
    assign res_lo    = st_q.lo;
    assign flags     = st_q.flags;
endmodule

// File: rtl/ash_unit_chk.sv
module ash_unit_chk #(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          dbl_mode,
    input logic          odd_pair,
    input logic [DW-1:0] opnd_hi,
    input logic [DW-1:0] opnd_lo,
    input logic [DW-1:0] shift_word,
    input logic          out_valid,
    input logic [DW-1:0] res_hi,
    input logic [DW-1:0] res_lo,
    input logic          pair_wr,
    input logic [3:0]    flags
);
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dbl_mode && shift_word[CW-1:0] == '0)
        |=> (res_lo == $past(opnd_lo) && flags[1:0] == 2'b00));

    assert_right_no_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_word[CW-1]) |=> !flags[1]);

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[2]) |-> (res_lo == '0 && res_hi == '0));

    assert_even_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dbl_mode && !odd_pair) |=> pair_wr);

    assert_odd_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pair_wr) |-> res_hi == '0);

    assert_flag_pack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(flags[3] && flags[2]));
endmodule

bind ash_unit ash_unit_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/ash_unit_tb.sv
module ash_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dbl_mode = 1'b0;
    logic        odd_pair = 1'b0;
    logic [15:0] opnd_hi = '0;
    logic [15:0] opnd_lo = '0;
    logic [15:0] shift_word = '0;
    logic        out_valid;
    logic [15:0] res_hi;
    logic [15:0] res_lo;
    logic        pair_wr;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ash_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_mode(dbl_mode),
        .odd_pair(odd_pair), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
        .shift_word(shift_word), .out_valid(out_valid), .res_hi(res_hi),
        .res_lo(res_lo), .pair_wr(pair_wr), .flags(flags)
    );

    // bit-at-a-time model: returns {pair, flags, hi, lo}
    function automatic logic [36:0] model(input logic dbl, input logic odd,
                                          input logic [15:0] hi, input logic [15:0] lo,
                                          input logic [15:0] sw);
        int          w = dbl ? 32 : 16;
        logic [31:0] v = dbl ? (odd ? {lo, lo} : {hi, lo}) : {16'h0, lo};
        int          n = sw[5] ? int'(sw[5:0]) - 64 : int'(sw[5:0]);
        logic        c = 1'b0;
        logic        ov = 1'b0;
        logic        sg;
        logic        z;
        logic        pr;
        for (int k = 0; k < n; k++) begin
            sg = v[w-1];
            c  = sg;
            v  = v << 1;
            if (w == 16) v[31:16] = '0;
            if (v[w-1] != sg) ov = 1'b1;
        end
        for (int k = 0; k < -n; k++) begin
            sg = v[w-1];
            c  = v[0];
            v  = v >> 1;
            v[w-1] = sg;
        end
        z  = (w == 16) ? (v[15:0] == 16'h0) : (v == 32'h0);
        pr = dbl && !odd;
        return {pr, v[w-1], z, ov, c, (pr ? v[31:16] : 16'h0), v[15:0]};
    endfunction

    task automatic apply(input logic dbl, input logic odd, input logic [15:0] hi,
                         input logic [15:0] lo, input logic [15:0] sw, input string tag);
        logic [36:0] exp_v;
        logic [36:0] got_v;
        exp_v = model(dbl, odd, hi, lo, sw);
        @(negedge clk);
        in_valid = 1'b1; dbl_mode = dbl; odd_pair = odd;
        opnd_hi = hi; opnd_lo = lo; shift_word = sw;
        @(negedge clk);
        in_valid = 1'b0; dbl_mode = 1'b0; odd_pair = 1'b0;
        opnd_hi = '0; opnd_lo = '0; shift_word = '0;
        got_v = {pair_wr, flags, res_hi, res_lo};
        n_checks++;
        if (!out_valid || got_v !== exp_v) begin
            n_fails++;
            $display("FAIL %s op=%h:%h sw=%h dbl=%0b odd=%0b got v=%0b %h exp v=1 %h",
                     tag, hi, lo, sw, dbl, odd, out_valid, got_v, exp_v);
        end
    endtask

    // directed vector with hand-derived expected values
    task automatic expect_fixed(input logic dbl, input logic odd, input logic [15:0] hi,
                                input logic [15:0] lo, input logic [15:0] sw,
                                input logic [3:0] ef, input logic [15:0] eh,
                                input logic [15:0] el, input string tag);
        @(negedge clk);
        in_valid = 1'b1; dbl_mode = dbl; odd_pair = odd;
        opnd_hi = hi; opnd_lo = lo; shift_word = sw;
        @(negedge clk);
        in_valid = 1'b0; dbl_mode = 1'b0; odd_pair = 1'b0;
        opnd_hi = '0; opnd_lo = '0; shift_word = '0;
        n_checks++;
        if (flags !== ef || res_hi !== eh || res_lo !== el) begin
            n_fails++;
            $display("FAIL %s got f=%b %h:%h exp f=%b %h:%h",
                     tag, flags, res_hi, res_lo, ef, eh, el);
        end
    endtask

    function automatic logic [15:0] next_rand(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic test_reset();
        n_checks++;
        if (out_valid !== 1'b0 || res_hi !== 16'h0 || res_lo !== 16'h0 ||
            pair_wr !== 1'b0 || flags !== 4'h0) begin
            n_fails++;
            $display("FAIL R9 reset got v=%b %h:%h p=%b f=%b exp all zero",
                     out_valid, res_hi, res_lo, pair_wr, flags);
        end
    endtask

    task automatic test_idle();
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R9 idle out_valid got %b exp 0", out_valid);
        end
    endtask

    task automatic test_fixed();
        // R5 R4: left 9, sign passes through bit 15 then clears
        expect_fixed(1'b0, 1'b0, 16'h0, 16'h0080, 16'd9, 4'b0111, 16'h0, 16'h0, "R5 sticky V");
        expect_fixed(1'b0, 1'b0, 16'h0, 16'h0080, 16'd7, 4'b0000, 16'h0, 16'h4000, "R2 left 7");
        // R1: 60 acts as -4, upper bits ignored
        expect_fixed(1'b0, 1'b0, 16'h0, 16'h0080, 16'hFFBC, 4'b0000, 16'h0, 16'h0008, "R1 wrap 60");
        // R1: 6'b011111 (-33 in 16 bits) acts as +31
        expect_fixed(1'b0, 1'b0, 16'h0, 16'h0080, 16'hFFDF, 4'b0110, 16'h0, 16'h0, "R1 wrap -33");
        // R3: negative word right by 16 -> all ones, C=1
        expect_fixed(1'b0, 1'b0, 16'h0, 16'h8080, 16'hFFF0, 4'b1001, 16'h0, 16'hFFFF, "R3 right 16");
        expect_fixed(1'b0, 1'b0, 16'h0, 16'h8080, 16'hFFF8, 4'b1001, 16'h0, 16'hFF80, "R3 right 8");
        // R4: zero count
        expect_fixed(1'b0, 1'b0, 16'h0, 16'h8080, 16'hFFC0, 4'b1000, 16'h0, 16'h8080, "R4 zero count");
        // R7: even pair right 4
        expect_fixed(1'b1, 1'b0, 16'h0010, 16'h0080, 16'h003C, 4'b0000, 16'h0001, 16'h0008, "R7 pair right");
        // R8: odd pair left 13 -> stored 0 but Z=0
        expect_fixed(1'b1, 1'b1, 16'hDEAD, 16'h0408, 16'd13, 4'b0011, 16'h0, 16'h0, "R8 odd Z=0");
        // R8: odd pair left 21 -> stored 0 with N=1
        expect_fixed(1'b1, 1'b1, 16'h0, 16'h0408, 16'd21, 4'b1010, 16'h0, 16'h0, "R8 odd N=1");
        // R8: odd pair right 4 -> bit 15 set, N=0, C=1
        expect_fixed(1'b1, 1'b1, 16'h0, 16'h0408, 16'hFFFC, 4'b0001, 16'h0, 16'h8040, "R8 odd right");
        // R10 R6: pair result negative
        expect_fixed(1'b1, 1'b0, 16'h8010, 16'h0080, 16'hFFE0, 4'b1001, 16'hFFFF, 16'hFFFF, "R6 pair neg");
    endtask

    task automatic test_sweep(input logic dbl, input logic odd, input string tag);
        for (int op = 0; op < 4; op++) begin
            for (int c = 0; c < 64; c++) begin
                logic [15:0] h;
                logic [15:0] l;
                lfsr = next_rand(lfsr); h = lfsr;
                lfsr = next_rand(lfsr); l = lfsr;
                if (op == 0) begin h = 16'h0020; l = 16'h0080; end
                if (op == 1) begin h = 16'h8000; l = 16'h0001; end
                apply(dbl, odd, h, l, {lfsr[15:6], 6'(c)}, tag);
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_fixed();
        test_idle();
        test_sweep(1'b0, 1'b0, "R1 R2 R3 R4 R5 single");
        test_sweep(1'b1, 1'b0, "R6 R7 even pair");
        test_sweep(1'b1, 1'b1, "R8 R10 odd pair");
        test_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule